// File: doc/BRIEF.md
# Parallel Display Bus Write/Read Bridge

This block turns single-beat memory-mapped requests from a system bus into timed cycles on an 8080-style parallel display bus. The display bus has an active-low chip select, active-low write and read strobes, a bidirectional 16-bit data bus, and a data/command line. The data/command line is not set by a control write. It is copied from one address bit of each accepted request, chosen by the parameter `DC_BIT`. Software places command accesses at a low address, where that bit is 0. It places pixel data accesses in a higher window, where that bit is 1. An incrementing burst over a frame buffer therefore stays in data mode for as long as its addresses leave that bit untouched.

Three inputs set the strobe timing: a setup count, a strobe count and a hold count. Each phase lasts its count plus one clock cycle. While a display cycle is in progress, a ready signal holds off the requester. A read returns the sampled bus value with a one-cycle valid pulse. After system reset, the bridge holds the display reset line low for a fixed number of cycles. A tearing-effect input is synchronized and turned into a one-cycle flag on each rising edge.

Top module: `dbi_bus_bridge`

## Requirements
- R1: While `rst` is high and just after it, `lcd_csn`, `lcd_wrn` and `lcd_rdn` are 1, `lcd_resn` is 0, `req_ready` is 0 and `te_flag` is 0.
- R2: After `rst` falls, `lcd_resn` rises on the `RST_CYCLES`-th clock edge. `req_ready` stays 0 while `lcd_resn` is 0 and first rises on the edge after `lcd_resn` rises.
- R3: `lcd_dcx` takes bit `DC_BIT` of the accepted request address on the accepting edge: 0 marks a command, 1 marks data. It changes at no other time.
- R4: A write cycle works as follows. `lcd_csn` is low alone for `setup_cyc`+1 cycles. `lcd_wrn` is then low for `strobe_cyc`+1 cycles while `lcd_data` carries `req_wdata`. `lcd_csn` stays low for `hold_cyc`+1 cycles after `lcd_wrn` rises, with the data still driven.
- R5: A read cycle uses the same phase lengths on `lcd_rdn`, and the bridge does not drive `lcd_data`. `rsp_rdata` is the bus value seen in the last strobe cycle. `rsp_valid` pulses for exactly one cycle, starting on the edge where `lcd_rdn` rises.
- R6: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 while `lcd_csn` is low and returns to 1 on the edge where `lcd_csn` rises. `lcd_wrn` and `lcd_rdn` are never low together, and neither is low unless `lcd_csn` is low.
- R7: In a run of writes to incrementing addresses that all have bit `DC_BIT` equal to 1, `lcd_dcx` stays 1 without a single change.
- R8: Each rising edge of `lcd_te` that is held for at least two cycles produces exactly one `te_flag` pulse, one cycle long. The flag is visible after the third clock edge that follows the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address; bit DC_BIT selects data/command |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Bridge can accept a request |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DATA_W | Read data |
| setup_cyc | input | CNT_W | Setup phase length minus one |
| strobe_cyc | input | CNT_W | Strobe phase length minus one |
| hold_cyc | input | CNT_W | Hold phase length minus one |
| lcd_csn | output | 1 | Display chip select, active low |
| lcd_wrn | output | 1 | Display write strobe, active low |
| lcd_rdn | output | 1 | Display read strobe, active low |
| lcd_dcx | output | 1 | 0 = command, 1 = data |
| lcd_data | inout | DATA_W | Bidirectional display data bus |
| lcd_resn | output | 1 | Display reset, active low |
| lcd_te | input | 1 | Tearing-effect input from the display |
| te_flag | output | 1 | One-cycle pulse per tearing-effect rising edge |

## Verification
The checker relies on three things about the inputs. First, the timing counts are held constant while a cycle is in flight. Second, the requester changes `req_valid` only between edges. Third, the display drives `lcd_data` only while `lcd_rdn` is low. The bench meets all three. It changes the counts only between transactions, drives requests at falling edges, and enables its bus driver from `lcd_rdn` itself. Tearing-effect pulses are kept at least two cycles wide and two cycles apart, which is the input range for which the one-flag-per-edge property is stated.

// File: rtl/dbi_bridge_pkg.sv
package dbi_bridge_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } bus_phase_e;

  function automatic int unsigned cnt_bits(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/dbi_reset_gen.sv
module dbi_reset_gen #(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  output logic resn
);
  localparam int unsigned CW = dbi_bridge_pkg::cnt_bits(RST_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      resn  <= 1'b0;
    end else if (!resn) begin
      if (cnt_q == LAST) resn <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dbi_te_sync.sv
module dbi_te_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic te_async,
  output logic te_flag
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= te_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= 1'b0;
      te_flag <= 1'b0;
    end else begin
      last_q  <= chain_q[STAGES-1];
      te_flag <= chain_q[STAGES-1] & ~last_q;
    end
  end
endmodule

// File: rtl/dbi_cycle_fsm.sv
module dbi_cycle_fsm
  import dbi_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DC_BIT = 20,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [CNT_W-1:0]  setup_cyc,
  input  logic [CNT_W-1:0]  strobe_cyc,
  input  logic [CNT_W-1:0]  hold_cyc,
  output logic              csn,
  output logic              wrn,
  output logic              rdn,
  output logic              dcx,
  output logic [DATA_W-1:0] dout,
  output logic              oe,
  input  logic [DATA_W-1:0] din
);
  bus_phase_e       ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             is_wr_q;
  logic             accept;
  logic             cnt_done;
  logic             unused_addr_bits;

  assign accept   = (ph_q == PH_IDLE) && req_ready && req_valid;
  assign cnt_done = (cnt_q == '0);
  assign unused_addr_bits = ^req_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      is_wr_q   <= 1'b0;
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      csn       <= 1'b1;
      wrn       <= 1'b1;
      rdn       <= 1'b1;
      dcx       <= 1'b0;
      dout      <= '0;
      oe        <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            req_ready <= 1'b0;
            csn       <= 1'b0;
            dcx       <= req_addr[DC_BIT];
            dout      <= req_wdata;
            oe        <= req_write;
            is_wr_q   <= req_write;
            cnt_q     <= setup_cyc;
            ph_q      <= PH_SETUP;
          end else begin
            req_ready <= enable;
          end
        end
        PH_SETUP: begin
          if (cnt_done) begin
            if (is_wr_q) wrn <= 1'b0;
            else         rdn <= 1'b0;
            cnt_q <= strobe_cyc;
            ph_q  <= PH_STROBE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt_done) begin
            wrn <= 1'b1;
            rdn <= 1'b1;
            if (!is_wr_q) begin
              rsp_rdata <= din;
              rsp_valid <= 1'b1;
            end
            cnt_q <= hold_cyc;
            ph_q  <= PH_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_done) begin
            csn       <= 1'b1;
            oe        <= 1'b0;
            req_ready <= enable;
            ph_q      <= PH_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbi_bus_bridge.sv
module dbi_bus_bridge #(
  parameter int unsigned ADDR_W     = 26,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned DC_BIT     = 20,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned RST_CYCLES = 16,
  parameter int unsigned TE_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [CNT_W-1:0]  setup_cyc,
  input  logic [CNT_W-1:0]  strobe_cyc,
  input  logic [CNT_W-1:0]  hold_cyc,
  output logic              lcd_csn,
  output logic              lcd_wrn,
  output logic              lcd_rdn,
  output logic              lcd_dcx,
  inout  wire  [DATA_W-1:0] lcd_data,
  output logic              lcd_resn,
  input  logic              lcd_te,
  output logic              te_flag
);
  logic [DATA_W-1:0] bus_out;
  logic              bus_oe;

  assign lcd_data = bus_oe ? bus_out : {DATA_W{1'bz}};

  dbi_reset_gen #(.RST_CYCLES(RST_CYCLES)) rstgen_i (
    .clk (clk),
    .rst (rst),
    .resn(lcd_resn)
  );

  dbi_cycle_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DC_BIT(DC_BIT), .CNT_W(CNT_W)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .enable    (lcd_resn),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .setup_cyc (setup_cyc),
    .strobe_cyc(strobe_cyc),
    .hold_cyc  (hold_cyc),
    .csn       (lcd_csn),
    .wrn       (lcd_wrn),
    .rdn       (lcd_rdn),
    .dcx       (lcd_dcx),
    .dout      (bus_out),
    .oe        (bus_oe),
    .din       (lcd_data)
  );

  dbi_te_sync #(.STAGES(TE_STAGES)) tesync_i (
    .clk     (clk),
    .rst     (rst),
    .te_async(lcd_te),
    .te_flag (te_flag)
  );
endmodule

// File: rtl/dbi_bus_bridge_chk.sv
module dbi_bus_bridge_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic lcd_csn,
  input logic lcd_wrn,
  input logic lcd_rdn,
  input logic lcd_dcx,
  input logic lcd_resn,
  input logic te_flag
);
  a_r6_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!lcd_wrn && !lcd_rdn));

  a_r6_strobe_needs_cs: assert property (@(posedge clk) disable iff (rst)
    (!lcd_wrn || !lcd_rdn) |-> !lcd_csn);

  a_r6_busy_while_cs: assert property (@(posedge clk) disable iff (rst)
    !lcd_csn |-> !req_ready);

  a_r3_dcx_changes_on_accept: assert property (@(posedge clk) disable iff (rst)
    !$stable(lcd_dcx) |-> $past(req_valid && req_ready));

  a_r2_no_ready_in_reset: assert property (@(posedge clk) disable iff (rst)
    !lcd_resn |-> !req_ready);

  a_r5_rsp_single: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r8_flag_single: assert property (@(posedge clk) disable iff (rst)
    te_flag |=> !te_flag);
endmodule

bind dbi_bus_bridge dbi_bus_bridge_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .lcd_csn  (lcd_csn),
  .lcd_wrn  (lcd_wrn),
  .lcd_rdn  (lcd_rdn),
  .lcd_dcx  (lcd_dcx),
  .lcd_resn (lcd_resn),
  .te_flag  (te_flag)
);

// File: tb/dbi_bus_bridge_tb_top.sv
`timescale 1ns/1ps
module dbi_bus_bridge_tb_top;
  localparam int ADDR_W = 26;
  localparam int DATA_W = 16;
  localparam int DC_BIT = 20;
  localparam int CNT_W  = 4;
  localparam int RSTC   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic [CNT_W-1:0] setup_cyc = '0, strobe_cyc = '0, hold_cyc = '0;
  logic lcd_csn, lcd_wrn, lcd_rdn, lcd_dcx, lcd_resn, te_flag;
  logic lcd_te = 1'b0;
  wire  [DATA_W-1:0] lcd_data;
  logic [DATA_W-1:0] tb_rd_val = '0;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  assign lcd_data = (!lcd_rdn) ? tb_rd_val : {DATA_W{1'bz}};

  dbi_bus_bridge #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DC_BIT(DC_BIT),
    .CNT_W(CNT_W), .RST_CYCLES(RSTC), .TE_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .setup_cyc(setup_cyc), .strobe_cyc(strobe_cyc), .hold_cyc(hold_cyc),
    .lcd_csn(lcd_csn), .lcd_wrn(lcd_wrn), .lcd_rdn(lcd_rdn),
    .lcd_dcx(lcd_dcx), .lcd_data(lcd_data), .lcd_resn(lcd_resn),
    .lcd_te(lcd_te), .te_flag(te_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int dcx_toggles = 0;
  bit dcx_watch = 0;
  logic dcx_prev = 1'b0;
  always @(negedge clk) begin
    if (dcx_watch && lcd_dcx !== dcx_prev) dcx_toggles++;
    dcx_prev <= lcd_dcx;
  end

  // One bus transaction; measures phase lengths from the pins.
  task automatic xfer(input bit wr, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input int s, input int p, input int h);
    int n_set = 0, n_str = 0, n_hold = 0, n_rsp = 0;
    bit strobed = 0, data_ok = 1, dcx_ok = 1, busy_ok = 1, both_ok = 1;
    logic [DATA_W-1:0] got = '0;
    logic [DATA_W-1:0] base = d ^ 16'h5a00;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    setup_cyc = CNT_W'(s); strobe_cyc = CNT_W'(p); hold_cyc = CNT_W'(h);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (lcd_csn) break;
      if (req_ready) busy_ok = 0;
      if (!lcd_wrn && !lcd_rdn) both_ok = 0;
      if (lcd_dcx !== a[DC_BIT]) dcx_ok = 0;
      if (rsp_valid) begin n_rsp++; got = rsp_rdata; end
      if (wr ? !lcd_wrn : !lcd_rdn) begin
        if (wr && lcd_data !== d) data_ok = 0;
        if (!wr) tb_rd_val = base + DATA_W'(n_str);
        n_str++; strobed = 1;
      end else if (!strobed) n_set++;
      else begin
        n_hold++;
        if (wr && lcd_data !== d) data_ok = 0;
      end
      @(negedge clk);
    end
    if (wr) begin
      chk(n_set == s + 1, "R4 setup", n_set, s + 1);
      chk(n_str == p + 1, "R4 strobe", n_str, p + 1);
      chk(n_hold == h + 1, "R4 hold", n_hold, h + 1);
      chk(data_ok, "R4 data", data_ok, 1);
    end else begin
      chk(n_set == s + 1, "R5 setup", n_set, s + 1);
      chk(n_str == p + 1, "R5 strobe", n_str, p + 1);
      chk(n_hold == h + 1, "R5 hold", n_hold, h + 1);
      chk(n_rsp == 1, "R5 valid pulses", n_rsp, 1);
      chk(got == base + DATA_W'(p), "R5 rdata", got, base + DATA_W'(p));
    end
    chk(dcx_ok, "R3 dcx", lcd_dcx, a[DC_BIT]);
    chk(busy_ok && req_ready, "R6 ready", req_ready, 1);
    chk(both_ok, "R6 strobes", both_ok, 1);
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n_low;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lcd_csn && lcd_wrn && lcd_rdn, "R1 strobes idle", {lcd_csn, lcd_wrn, lcd_rdn}, 7);
    chk(!lcd_resn, "R1 resn", lcd_resn, 0);
    chk(!req_ready, "R1 ready", req_ready, 0);
    chk(!te_flag, "R1 te_flag", te_flag, 0);
    rst = 1'b0;
    // R2 display reset release
    n_low = 0;
    forever begin
      @(negedge clk);
      if (lcd_resn) break;
      n_low++;
      if (req_ready) chk(0, "R2 ready early", 1, 0);
    end
    chk(n_low == RSTC - 1, "R2 resn low length", n_low, RSTC - 1);
    chk(!req_ready, "R2 ready lags resn", req_ready, 0);
    @(negedge clk);
    chk(req_ready, "R2 ready up", req_ready, 1);

    // R4/R5 sweep of every timing combination 0..2
    for (int s = 0; s < 3; s++)
      for (int p = 0; p < 3; p++)
        for (int h = 0; h < 3; h++) begin
          xfer(1'b0 == 1'b1, 26'h0000004, 16'h0, s, p, h);
          xfer(1'b1, 26'h0000004 + 26'(s), 16'h1234 + 16'(s*9 + p*3 + h), s, p, h);
          xfer(1'b1, 26'h0100000 + 26'(p), 16'hA000 + 16'(h), s, p, h);
          xfer(1'b0, 26'h0100010, 16'hC3C3 ^ 16'(s + p + h), s, p, h);
        end

    // R7 incrementing data burst keeps dcx at 1
    xfer(1'b1, 26'h0100000, 16'h0001, 0, 0, 0);
    dcx_toggles = 0; dcx_watch = 1;
    for (int i = 0; i < 12; i++)
      xfer(1'b1, 26'h0100000 + 26'(i * 2), 16'(i * 257), 1, 0, 1);
    dcx_watch = 0;
    chk(dcx_toggles == 0, "R7 dcx burst stable", dcx_toggles, 0);
    chk(lcd_dcx, "R7 dcx data", lcd_dcx, 1);
    xfer(1'b1, 26'h00FFFFF, 16'h002C, 0, 1, 0);
    chk(!lcd_dcx, "R3 command after burst", lcd_dcx, 0);

    // R8 tearing-effect flag latency and count
    begin
      int pulses = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); lcd_te = 1'b1;
        @(negedge clk); chk(!te_flag, "R8 latency e1", te_flag, 0);
        @(negedge clk); chk(!te_flag, "R8 latency e2", te_flag, 0);
        @(negedge clk); chk(te_flag, "R8 latency e3", te_flag, 1);
        pulses += te_flag;
        lcd_te = 1'b0;
        for (int j = 0; j < 5; j++) begin
          @(negedge clk); pulses += te_flag;
        end
      end
      chk(pulses == 4, "R8 one flag per edge", pulses, 4);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule